// File: doc/BRIEF.md
# Partition Label Register with Access Checking

This block holds a 64-bit system register for the least-privileged execution level. The register stores two partition identifiers and two monitoring-group tags, one pair for instruction fetches and one pair for data loads and stores. It does two jobs.

First, it checks a decoded system-register access against the current privilege level (0 to 3). It also takes the trap controls of the two highest levels and the debug-halt state. From these it decides whether the access completes, traps to level 2 or level 3, or is undefined. The decision is reported one cycle later, together with read data on a completed read.

Second, it provides a combinational label port. For each memory request this port picks the identifier and group that match the request kind. Under a set of virtualization controls it can instead take the labels from the level-1 label register.

The stored value comes out of reset as zero. Software must still write the register before it relies on any label.

Top module: `plabel_reg`

## Requirements
- R1: An access responds only when `req_enc_i` equals 16'hC529, which is the field packing {2'b11, 3'b000, 4'b1010, 4'b0101, 3'b001}. That one code selects the register for both reads and writes. With any other code, `rsp_valid_o` stays low on the next cycle and the stored value is unchanged.
- R2: A matching request produces `rsp_valid_o` exactly one cycle later. Exactly one of `rsp_done_o`, `rsp_trap_o` or `rsp_undef_o` is high while `rsp_valid_o` is high, and all three are low otherwise.
- R3: Any access made at privilege level 0 is undefined.
- R4: At level 1 or 2, if level 3 exists and its lower-level trap bit is set, the access traps with target 3 and syndrome class 6'h18. If the core is also halted in debug with secure debug disabled, the access is undefined instead.
- R5: At level 1, when R4 does not apply, the access traps with target 2 and class 6'h18 if level 2 is enabled and its trap bit is set.
- R6: An access at level 3 always completes. An access at level 2 completes whenever R4 does not apply, whatever the level-2 trap bit is.
- R7: A completed write stores bits 47:0 of the write data in one cycle. Bits 63:48 are ignored and always read as zero.
- R8: A trapped or undefined write leaves the stored value unchanged.
- R9: The label port gives instruction fetches the identifier in bits 15:0 and the group in bits 39:32. It gives data accesses the identifier in bits 31:16 and the group in bits 47:40.
- R10: When level 2 is enabled, the virtualization option is present, the guest-application control is 1 and the trap-general control is 0, the labels come from `alt_label_i` instead. That input uses the same field layout.
- R11: A completed read returns the stored register on `rdata_o`. Every other response drives `rdata_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Decoded system-register access present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_enc_i | input | 16 | Packed register encoding |
| priv_lvl_i | input | 2 | Current privilege level |
| lvl3_present_i | input | 1 | Level 3 implemented |
| lvl3_trap_low_i | input | 1 | Level-3 trap of lower-level accesses |
| lvl2_enabled_i | input | 1 | Level 2 present and enabled |
| lvl2_trap_i | input | 1 | Level-2 trap of this register |
| dbg_halted_i | input | 1 | Core halted in debug |
| dbg_sec_dis_i | input | 1 | Secure debug disabled |
| wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Response present |
| rsp_done_o | output | 1 | Access completed |
| rsp_trap_o | output | 1 | Access trapped |
| rsp_undef_o | output | 1 | Access undefined |
| rsp_tgt_lvl_o | output | 2 | Trap target level (2 or 3) |
| rsp_class_o | output | 6 | Trap syndrome class |
| rdata_o | output | 64 | Read data |
| lbl_fetch_i | input | 1 | Label request is an instruction fetch |
| virt_opt_i | input | 1 | Virtualization option present |
| guest_app_i | input | 1 | Guest-application label control |
| tge_i | input | 1 | Trap-general-exceptions control |
| alt_label_i | input | 48 | Level-1 label register fields |
| lbl_id_o | output | 16 | Selected partition identifier |
| lbl_grp_o | output | 8 | Selected monitoring group |

## Verification
Every access result is due exactly one clock edge after the request edge. This covers the three outcome flags, the trap target and class, and the read data. The stored value also updates on that same edge. The labels are combinational, so they follow a stored write or a change of the select inputs within the same cycle. Each task drives its request on a falling edge and holds it through one rising edge. It then samples the response on the next falling edge, which is the single cycle where the result is defined, and drops the request before that edge. Ignored writes are checked with a completing read from level 3 after each trapped or undefined write.

// File: rtl/plabel_pkg.sv
package plabel_pkg;
  localparam int unsigned DATA_W  = 64;
  localparam int unsigned ID_W    = 16;
  localparam int unsigned GRP_W   = 8;
  localparam int unsigned LVL_W   = 2;
  localparam int unsigned CLASS_W = 6;
  localparam int unsigned ENC_W   = 16;
  localparam int unsigned FIELD_W = 2 * ID_W + 2 * GRP_W;

  // field positions, consumed by label selection
  localparam int unsigned IID_LSB  = 0;
  localparam int unsigned DID_LSB  = ID_W;
  localparam int unsigned IGRP_LSB = 2 * ID_W;
  localparam int unsigned DGRP_LSB = 2 * ID_W + GRP_W;

  typedef enum logic [1:0] {
    OUT_DONE  = 2'd0,
    OUT_TRAP  = 2'd1,
    OUT_UNDEF = 2'd2
  } outcome_e;
endpackage

// File: rtl/plabel_access_chk.sv
module plabel_access_chk
  import plabel_pkg::*;
(
  input  logic [LVL_W-1:0] priv_lvl_i,
  input  logic             lvl3_present_i,
  input  logic             lvl3_trap_low_i,
  input  logic             lvl2_enabled_i,
  input  logic             lvl2_trap_i,
  input  logic             dbg_halted_i,
  input  logic             dbg_sec_dis_i,
  output outcome_e         outcome_o,
  output logic [LVL_W-1:0] tgt_lvl_o
);
  logic top_trap;
  logic dbg_block;

  assign top_trap  = lvl3_present_i && lvl3_trap_low_i;
  assign dbg_block = dbg_halted_i && dbg_sec_dis_i;

  // priority chain: level-3 trap, then level-2 trap, then completion
  always_comb begin
    outcome_o = OUT_DONE;
    tgt_lvl_o = '0;
    unique case (priv_lvl_i)
      2'd0: outcome_o = OUT_UNDEF;
      2'd1: begin
        if (top_trap) begin
          outcome_o = dbg_block ? OUT_UNDEF : OUT_TRAP;
          tgt_lvl_o = dbg_block ? '0 : LVL_W'(3);
        end else if (lvl2_enabled_i && lvl2_trap_i) begin
          outcome_o = OUT_TRAP;
          tgt_lvl_o = LVL_W'(2);
        end
      end
      2'd2: begin
        if (top_trap) begin
          outcome_o = dbg_block ? OUT_UNDEF : OUT_TRAP;
          tgt_lvl_o = dbg_block ? '0 : LVL_W'(3);
        end
      end
      default: outcome_o = OUT_DONE;
    endcase
  end
endmodule

// File: rtl/plabel_store.sv
module plabel_store
  import plabel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  localparam logic [DATA_W-1:0] KEEP_MASK = {{(DATA_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (wr_en_i) q_o <= wdata_i & KEEP_MASK;
  end

  assert_rsvd_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o[DATA_W-1:FIELD_W] == '0);
endmodule

// File: rtl/plabel_label_sel.sv
module plabel_label_sel
  import plabel_pkg::*;
(
  input  logic [FIELD_W-1:0] own_i,
  input  logic [FIELD_W-1:0] alt_i,
  input  logic               use_alt_i,
  input  logic               fetch_i,
  output logic [ID_W-1:0]    id_o,
  output logic [GRP_W-1:0]   grp_o
);
  logic [FIELD_W-1:0] src;

  assign src   = use_alt_i ? alt_i : own_i;
  assign id_o  = fetch_i ? src[IID_LSB +: ID_W]   : src[DID_LSB +: ID_W];
  assign grp_o = fetch_i ? src[IGRP_LSB +: GRP_W] : src[DGRP_LSB +: GRP_W];
endmodule

// File: rtl/plabel_reg.sv
module plabel_reg
  import plabel_pkg::*;
#(
  parameter logic [ENC_W-1:0]   SEL_ENC    = 16'hC529,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [ENC_W-1:0]   req_enc_i,
  input  logic [LVL_W-1:0]   priv_lvl_i,
  input  logic               lvl3_present_i,
  input  logic               lvl3_trap_low_i,
  input  logic               lvl2_enabled_i,
  input  logic               lvl2_trap_i,
  input  logic               dbg_halted_i,
  input  logic               dbg_sec_dis_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               rsp_valid_o,
  output logic               rsp_done_o,
  output logic               rsp_trap_o,
  output logic               rsp_undef_o,
  output logic [LVL_W-1:0]   rsp_tgt_lvl_o,
  output logic [CLASS_W-1:0] rsp_class_o,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               lbl_fetch_i,
  input  logic               virt_opt_i,
  input  logic               guest_app_i,
  input  logic               tge_i,
  input  logic [FIELD_W-1:0] alt_label_i,
  output logic [ID_W-1:0]    lbl_id_o,
  output logic [GRP_W-1:0]   lbl_grp_o
);
  outcome_e          outcome;
  logic [LVL_W-1:0]  tgt_lvl;
  logic              hit;
  logic              wr_en;
  logic [DATA_W-1:0] reg_q;
  logic              use_alt;

  assign hit   = req_valid_i && (req_enc_i == SEL_ENC);
  assign wr_en = hit && req_write_i && (outcome == OUT_DONE);

  plabel_access_chk u_chk (
    .priv_lvl_i     (priv_lvl_i),
    .lvl3_present_i (lvl3_present_i),
    .lvl3_trap_low_i(lvl3_trap_low_i),
    .lvl2_enabled_i (lvl2_enabled_i),
    .lvl2_trap_i    (lvl2_trap_i),
    .dbg_halted_i   (dbg_halted_i),
    .dbg_sec_dis_i  (dbg_sec_dis_i),
    .outcome_o      (outcome),
    .tgt_lvl_o      (tgt_lvl)
  );

  plabel_store u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en),
    .wdata_i(wdata_i),
    .q_o    (reg_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_done_o    <= 1'b0;
      rsp_trap_o    <= 1'b0;
      rsp_undef_o   <= 1'b0;
      rsp_tgt_lvl_o <= '0;
      rsp_class_o   <= '0;
      rdata_o       <= '0;
    end else begin
      rsp_valid_o   <= hit;
      rsp_done_o    <= hit && (outcome == OUT_DONE);
      rsp_trap_o    <= hit && (outcome == OUT_TRAP);
      rsp_undef_o   <= hit && (outcome == OUT_UNDEF);
      rsp_tgt_lvl_o <= hit ? tgt_lvl : '0;
      rsp_class_o   <= (hit && outcome == OUT_TRAP) ? TRAP_CLASS : '0;
      rdata_o       <= (hit && !req_write_i && outcome == OUT_DONE) ? reg_q : '0;
    end
  end

  assign use_alt = lvl2_enabled_i && virt_opt_i && guest_app_i && !tge_i;

  plabel_label_sel u_sel (
    .own_i    (reg_q[FIELD_W-1:0]),
    .alt_i    (alt_label_i),
    .use_alt_i(use_alt),
    .fetch_i  (lbl_fetch_i),
    .id_o     (lbl_id_o),
    .grp_o    (lbl_grp_o)
  );

  assert_no_rsp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_enc_i != SEL_ENC) |=> !rsp_valid_o);
  assert_one_outcome_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({rsp_done_o, rsp_trap_o, rsp_undef_o}) == 1);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !(rsp_done_o || rsp_trap_o || rsp_undef_o));
  assert_low_undef_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && priv_lvl_i == '0) |=> rsp_undef_o);
  assert_trap_tgt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_trap_o |-> ((rsp_tgt_lvl_o == 2'd2 || rsp_tgt_lvl_o == 2'd3) && rsp_class_o == TRAP_CLASS));
  assert_top_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && priv_lvl_i == 2'd3) |=> rsp_done_o);
  assert_keep_value_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_done_o) |-> reg_q == $past(reg_q));
  assert_rdata_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_done_o |-> rdata_o == '0);
endmodule

// File: tb/plabel_reg_tb_top.sv
module plabel_reg_tb_top;
  localparam logic [15:0] ENC = 16'hC529;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [15:0] req_enc_i = '0;
  logic [1:0]  priv_lvl_i = '0;
  logic        lvl3_present_i = 1'b0, lvl3_trap_low_i = 1'b0;
  logic        lvl2_enabled_i = 1'b0, lvl2_trap_i = 1'b0;
  logic        dbg_halted_i = 1'b0, dbg_sec_dis_i = 1'b0;
  logic [63:0] wdata_i = '0;
  logic        rsp_valid_o, rsp_done_o, rsp_trap_o, rsp_undef_o;
  logic [1:0]  rsp_tgt_lvl_o;
  logic [5:0]  rsp_class_o;
  logic [63:0] rdata_o;
  logic        lbl_fetch_i = 1'b0, virt_opt_i = 1'b0, guest_app_i = 1'b0, tge_i = 1'b0;
  logic [47:0] alt_label_i = '0;
  logic [15:0] lbl_id_o;
  logic [7:0]  lbl_grp_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [47:0] model = '0;

  always #10 clk_i = ~clk_i;

  plabel_reg dut_i (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one request; response sampled on the falling edge after the capture edge
  task automatic access(input logic wr, input logic [1:0] lvl, input logic [15:0] enc,
                        input logic [63:0] d);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = wr; priv_lvl_i = lvl; req_enc_i = enc; wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic clear_ctl();
    lvl3_present_i = 0; lvl3_trap_low_i = 0; lvl2_enabled_i = 0; lvl2_trap_i = 0;
    dbg_halted_i = 0; dbg_sec_dis_i = 0;
  endtask

  task automatic outcome(input string req, input logic d, input logic t, input logic u,
                         input logic [1:0] tgt);
    chk(req, {rsp_valid_o, rsp_done_o, rsp_trap_o, rsp_undef_o}, {1'b1, d, t, u});
    if (t) chk(req, {rsp_tgt_lvl_o, rsp_class_o}, {tgt, 6'h18});
  endtask

  task automatic readback(input string req);
    logic [1:0] sv_l3 = {lvl3_present_i, lvl3_trap_low_i};
    lvl3_present_i = 0;
    access(1'b0, 2'd3, ENC, '0);
    chk(req, rdata_o, {16'h0, model});
    {lvl3_present_i, lvl3_trap_low_i} = sv_l3;
  endtask

  task automatic t_reset();
    chk("R2 reset", {rsp_valid_o, rsp_done_o, rsp_trap_o, rsp_undef_o, rdata_o}, '0);
  endtask

  task automatic t_complete();
    clear_ctl();
    access(1'b1, 2'd3, ENC, 64'hFFFF_A5C3_1234_5678);
    model = 48'hA5C3_1234_5678;
    outcome("R6 lvl3 write", 1, 0, 0, 0);
    chk("R11 write rdata", rdata_o, '0);
    access(1'b0, 2'd3, ENC, '0);
    outcome("R6 lvl3 read", 1, 0, 0, 0);
    chk("R7 R11 read value", rdata_o, 64'h0000_A5C3_1234_5678);
    lvl2_enabled_i = 1; lvl2_trap_i = 1;
    access(1'b1, 2'd2, ENC, 64'h1111_0B0A_0002_0001);
    model = 48'h0B0A_0002_0001;
    outcome("R6 lvl2 ignores lvl2 trap", 1, 0, 0, 0);
    readback("R7 lvl2 write stored");
    lvl2_trap_i = 0;
    access(1'b1, 2'd1, ENC, 64'h0000_7766_5544_3322);
    model = 48'h7766_5544_3322;
    outcome("R6 lvl1 completes", 1, 0, 0, 0);
    readback("R7 lvl1 write stored");
  endtask

  task automatic t_nomatch();
    clear_ctl();
    access(1'b1, 2'd3, ENC ^ 16'h0001, 64'hDEAD_BEEF_DEAD_BEEF);
    chk("R1 no response", {rsp_valid_o, rsp_done_o, rsp_trap_o, rsp_undef_o}, '0);
    readback("R1 value kept");
  endtask

  task automatic t_lvl0();
    clear_ctl();
    access(1'b1, 2'd0, ENC, 64'h0000_1234_1234_1234);
    outcome("R3 lvl0 write", 0, 0, 1, 0);
    readback("R8 lvl0 write ignored");
    access(1'b0, 2'd0, ENC, '0);
    outcome("R3 lvl0 read", 0, 0, 1, 0);
    chk("R11 undef rdata", rdata_o, '0);
  endtask

  task automatic t_trap3();
    clear_ctl();
    lvl3_present_i = 1; lvl3_trap_low_i = 1; lvl2_enabled_i = 1; lvl2_trap_i = 1;
    access(1'b1, 2'd1, ENC, 64'h0000_9999_9999_9999);
    outcome("R4 lvl1 to lvl3 over lvl2", 0, 1, 0, 2'd3);
    readback("R8 trapped write ignored");
    access(1'b0, 2'd2, ENC, '0);
    outcome("R4 lvl2 to lvl3", 0, 1, 0, 2'd3);
    chk("R11 trap rdata", rdata_o, '0);
    dbg_halted_i = 1; dbg_sec_dis_i = 1;
    access(1'b1, 2'd2, ENC, 64'h0000_8888_8888_8888);
    outcome("R4 debug undef", 0, 0, 1, 0);
    readback("R8 debug undef ignored");
    dbg_sec_dis_i = 0;
    access(1'b0, 2'd1, ENC, '0);
    outcome("R4 halted only traps", 0, 1, 0, 2'd3);
    dbg_sec_dis_i = 1; lvl3_present_i = 0;
    access(1'b0, 2'd3, ENC, '0);
    outcome("R6 lvl3 always done", 1, 0, 0, 0);
  endtask

  task automatic t_trap2();
    clear_ctl();
    lvl2_enabled_i = 1; lvl2_trap_i = 1;
    access(1'b1, 2'd1, ENC, 64'h0000_4444_4444_4444);
    outcome("R5 lvl1 to lvl2", 0, 1, 0, 2'd2);
    readback("R8 lvl2 trap ignored");
    lvl2_enabled_i = 0;
    access(1'b0, 2'd1, ENC, '0);
    outcome("R5 lvl2 disabled", 1, 0, 0, 0);
    lvl3_present_i = 0; lvl3_trap_low_i = 1; lvl2_enabled_i = 1;
    access(1'b0, 2'd1, ENC, '0);
    outcome("R4 R5 absent lvl3 falls to lvl2", 0, 1, 0, 2'd2);
  endtask

  task automatic t_labels();
    clear_ctl();
    access(1'b1, 2'd3, ENC, 64'h0000_A5C3_1234_5678);
    model = 48'hA5C3_1234_5678;
    alt_label_i = 48'h2211_BBBB_AAAA;
    lbl_fetch_i = 1; #1;
    chk("R9 fetch label", {lbl_id_o, lbl_grp_o}, {16'h5678, 8'hC3});
    lbl_fetch_i = 0; #1;
    chk("R9 data label", {lbl_id_o, lbl_grp_o}, {16'h1234, 8'hA5});
    lvl2_enabled_i = 1; virt_opt_i = 1; guest_app_i = 1; tge_i = 0; #1;
    chk("R10 data alt", {lbl_id_o, lbl_grp_o}, {16'hBBBB, 8'h22});
    lbl_fetch_i = 1; #1;
    chk("R10 fetch alt", {lbl_id_o, lbl_grp_o}, {16'hAAAA, 8'h11});
    tge_i = 1; #1;
    chk("R10 tge blocks", {lbl_id_o, lbl_grp_o}, {16'h5678, 8'hC3});
    tge_i = 0; guest_app_i = 0; #1;
    chk("R10 guest ctl off", {lbl_id_o, lbl_grp_o}, {16'h5678, 8'hC3});
    guest_app_i = 1; lvl2_enabled_i = 0; #1;
    chk("R10 lvl2 off", {lbl_id_o, lbl_grp_o}, {16'h5678, 8'hC3});
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_complete();
        t_nomatch();
        t_lvl0();
        t_trap3();
        t_trap2();
        t_labels();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule